// File: doc/BRIEF.md
# Instruction Field Decoder

This block takes one 32-bit instruction word of a classic fixed-width load/store instruction set, together with the fetch-ahead program counter (the address of the instruction after the one being decoded) and the two source register values read for it. It splits the word into its fields and works out which lookup class picks the operation. It also builds every operand-side value that an execute stage needs: the destination register index, the control-transfer target, the extended immediate, the effective memory address, both arithmetic source operands and the memory access width. Two fault conditions are raised for an execute stage to act on. One marks an encoding outside the supported subset. The other marks a memory access whose address is not aligned to its width.

All results are captured into one output register stage when `in_valid` is high, so they appear together one clock later with `out_valid`. When `in_valid` is low, the captured results hold their previous values. Executing the operation and writing a result back are left to later stages.

Top module: `insn_field_decoder`

## Requirements
- R1: Outputs are registered. One clock after an edge where `in_valid` is 1, `out_valid` is 1 and the field outputs carry bits of that word: `f_op`=[31:26], `f_rs`=[25:21], `f_rt`=[20:16], `f_rd`=[15:11], `f_sh`=[10:6], `f_func`=[5:0], `f_target`=[25:0]. After an edge with `in_valid` 0, `out_valid` is 0. Reset clears every output to 0.
- R2: `tbl_class` is 1 when the op field is 0, so the operation is chosen by func. It is 2 when the op field is 1, so the operation is chosen by the rt field. Every other op value gives 0, and the operation is chosen by op.
- R3: The supported set is as follows. With op 0, func must be one of 0x00, 0x02, 0x03, 0x04, 0x06, 0x07, 0x08, 0x09, 0x20..0x27, 0x2A or 0x2B. With op 1, rt must be one of 0x00, 0x01, 0x10 or 0x11. Any other op must be 0x02..0x0F, 0x20, 0x21, 0x23, 0x24, 0x25, 0x28, 0x29 or 0x2B. Anything else sets `illegal` to 1, `ifmt` to 3 (no format), `dst_valid` to 0, `dst_idx` to 0 and `acc_size` to 0.
- R4: `ifmt` is 0 (register format) for op 0 and 2 (jump format) for op 2 and 3. All other legal encodings give 1 (immediate format). The destination is set as follows. Op 3, and op 1 with rt 0x10 or 0x11, link and give index 31. Otherwise register format gives rd, immediate format gives rt, and jump format gives no destination (`dst_valid` 0, `dst_idx` 0).
- R5: `jtarget` depends on the format. Register format gives the rs value. Immediate format gives next_pc + (sign-extended imm × 4). Jump format gives next_pc[31:28] concatenated with target and two zero bits. No format gives 0xFFFFFFFF.
- R6: `imm_ext` is bits [15:0] zero-extended for op 0x0C..0x0F and sign-extended for every other encoding.
- R7: `addr` equals the rs value plus `imm_ext`, modulo 2^32.
- R8: `src1` is the sh field zero-extended for op 0 with func 0x00, 0x02 or 0x03. Otherwise it is the rs value.
- R9: `src2` is `imm_ext` for op 0x08..0x0F. Otherwise it is the rt value.
- R10: `acc_size` is the access width in bytes: 1 for op 0x20, 0x24 and 0x28, 2 for op 0x21, 0x25 and 0x29, 4 for op 0x23 and 0x2B, and 0 otherwise.
- R11: `addr_err` is 1 when `acc_size` is 4 and addr[1:0] is nonzero, or when `acc_size` is 2 and addr[0] is 1. Otherwise it is 0.
- R12: While `in_valid` is 0, every data output keeps the value captured from the last accepted word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Capture the word and operands at this edge |
| instr | input | 32 | Instruction word |
| next_pc | input | 32 | Address of the following instruction |
| rs_data | input | 32 | Value read from register rs |
| rt_data | input | 32 | Value read from register rt |
| out_valid | output | 1 | Outputs belong to a word accepted at the previous edge |
| f_op | output | 6 | Op field |
| f_rs | output | 5 | rs field |
| f_rt | output | 5 | rt field |
| f_rd | output | 5 | rd field |
| f_sh | output | 5 | Shift amount field |
| f_func | output | 6 | Function field |
| f_target | output | 26 | Jump target field |
| tbl_class | output | 2 | Lookup class: 0 op, 1 func, 2 rt |
| ifmt | output | 2 | Format: 0 register, 1 immediate, 2 jump, 3 none |
| illegal | output | 1 | Unsupported encoding |
| dst_valid | output | 1 | A destination register exists |
| dst_idx | output | 5 | Destination register index |
| imm_ext | output | 32 | Extended immediate |
| jtarget | output | 32 | Control-transfer target |
| addr | output | 32 | Effective address |
| src1 | output | 32 | First arithmetic operand |
| src2 | output | 32 | Second arithmetic operand |
| acc_size | output | 3 | Memory access width in bytes |
| addr_err | output | 1 | Misaligned memory access |

## Verification
Every result is combinational from the word and operands sampled at one rising edge, and is then registered, so all of them are due exactly one clock after the edge that accepts the word. The bench changes inputs on the falling edge. At the next falling edge it compares every output against a behavioural model of the last accepted word. During idle cycles it compares against the same held expectation, which also checks that outputs hold.

// File: rtl/idec_pkg.sv
package idec_pkg;

  localparam int IW    = 32;
  localparam int RIW   = 5;
  localparam int OPW   = 6;
  localparam int FNW   = 6;
  localparam int TGW   = 26;
  localparam int IMMW  = 16;
  localparam int SZW   = 3;
  localparam int SEGW  = IW - TGW - 2;

  typedef enum logic [1:0] {
    FMT_R    = 2'd0,
    FMT_I    = 2'd1,
    FMT_J    = 2'd2,
    FMT_NONE = 2'd3
  } fmt_e;

  typedef enum logic [1:0] {
    CLS_OP   = 2'd0,
    CLS_FUNC = 2'd1,
    CLS_RT   = 2'd2
  } cls_e;

  typedef struct packed {
    logic             legal;
    fmt_e             fmt;
    logic             sh_is_src1;
    logic             imm_is_src2;
    logic             zext;
    logic             link;
    logic [SZW-1:0]   size;
  } ctl_t;

  function automatic ctl_t mk_ctl(fmt_e f, logic sh1, logic im2, logic zx,
                                  logic lnk, logic [SZW-1:0] sz);
    ctl_t c;
    c.legal       = 1'b1;
    c.fmt         = f;
    c.sh_is_src1  = sh1;
    c.imm_is_src2 = im2;
    c.zext        = zx;
    c.link        = lnk;
    c.size        = sz;
    return c;
  endfunction

  function automatic ctl_t bad_ctl();
    ctl_t c;
    c = '0;
    c.fmt = FMT_NONE;
    return c;
  endfunction

  function automatic logic [IW-1:0] widen_imm(logic [IMMW-1:0] v, logic zx);
    return zx ? {{(IW-IMMW){1'b0}}, v} : {{(IW-IMMW){v[IMMW-1]}}, v};
  endfunction

  function automatic logic [IW-1:0] rel_target(logic [IW-1:0] base,
                                               logic [IW-1:0] simm);
    return base + (simm << 2);
  endfunction

  function automatic logic [IW-1:0] seg_target(logic [SEGW-1:0] seg,
                                               logic [TGW-1:0] t);
    return {seg, t, 2'b00};
  endfunction

  function automatic logic is_misaligned(logic [1:0] low, logic [SZW-1:0] sz);
    return ((sz == SZW'(4)) && (low != 2'b00)) ||
           ((sz == SZW'(2)) && low[0]);
  endfunction

endpackage

// File: rtl/idec_fields.sv
module idec_fields
  import idec_pkg::*;
(
  input  logic [IW-1:0]   word,
  output logic [OPW-1:0]  op,
  output logic [RIW-1:0]  rs,
  output logic [RIW-1:0]  rt,
  output logic [RIW-1:0]  rd,
  output logic [RIW-1:0]  sh,
  output logic [FNW-1:0]  fn,
  output logic [TGW-1:0]  tgt,
  output logic [IMMW-1:0] imm16
);

  localparam int OP_LO = IW - OPW;
  localparam int RS_LO = OP_LO - RIW;
  localparam int RT_LO = RS_LO - RIW;
  localparam int RD_LO = RT_LO - RIW;
  localparam int SH_LO = RD_LO - RIW;

  always_comb begin
    op    = word[OP_LO +: OPW];
    rs    = word[RS_LO +: RIW];
    rt    = word[RT_LO +: RIW];
    rd    = word[RD_LO +: RIW];
    sh    = word[SH_LO +: RIW];
    fn    = word[0 +: FNW];
    tgt   = word[0 +: TGW];
    imm16 = word[0 +: IMMW];
  end

endmodule

// File: rtl/idec_table.sv
module idec_table
  import idec_pkg::*;
(
  input  logic [OPW-1:0] op,
  input  logic [RIW-1:0] rt,
  input  logic [FNW-1:0] fn,
  output cls_e           cls,
  output ctl_t           ctl
);

  ctl_t func_ctl;
  ctl_t rt_ctl;
  ctl_t op_ctl;

  always_comb begin
    case (fn)
      6'h00, 6'h02, 6'h03:
        func_ctl = mk_ctl(FMT_R, 1'b1, 1'b0, 1'b0, 1'b0, 3'd0);
      6'h04, 6'h06, 6'h07, 6'h08, 6'h09,
      6'h20, 6'h21, 6'h22, 6'h23, 6'h24, 6'h25, 6'h26, 6'h27,
      6'h2A, 6'h2B:
        func_ctl = mk_ctl(FMT_R, 1'b0, 1'b0, 1'b0, 1'b0, 3'd0);
      default:
        func_ctl = bad_ctl();
    endcase
  end

  always_comb begin
    case (rt)
      5'h00, 5'h01:
        rt_ctl = mk_ctl(FMT_I, 1'b0, 1'b0, 1'b0, 1'b0, 3'd0);
      5'h10, 5'h11:
        rt_ctl = mk_ctl(FMT_I, 1'b0, 1'b0, 1'b0, 1'b1, 3'd0);
      default:
        rt_ctl = bad_ctl();
    endcase
  end

  always_comb begin
    case (op)
      6'h02: op_ctl = mk_ctl(FMT_J, 1'b0, 1'b0, 1'b0, 1'b0, 3'd0);
      6'h03: op_ctl = mk_ctl(FMT_J, 1'b0, 1'b0, 1'b0, 1'b1, 3'd0);
      6'h04, 6'h05, 6'h06, 6'h07:
             op_ctl = mk_ctl(FMT_I, 1'b0, 1'b0, 1'b0, 1'b0, 3'd0);
      6'h08, 6'h09, 6'h0A, 6'h0B:
             op_ctl = mk_ctl(FMT_I, 1'b0, 1'b1, 1'b0, 1'b0, 3'd0);
      6'h0C, 6'h0D, 6'h0E, 6'h0F:
             op_ctl = mk_ctl(FMT_I, 1'b0, 1'b1, 1'b1, 1'b0, 3'd0);
      6'h20, 6'h24, 6'h28:
             op_ctl = mk_ctl(FMT_I, 1'b0, 1'b0, 1'b0, 1'b0, 3'd1);
      6'h21, 6'h25, 6'h29:
             op_ctl = mk_ctl(FMT_I, 1'b0, 1'b0, 1'b0, 1'b0, 3'd2);
      6'h23, 6'h2B:
             op_ctl = mk_ctl(FMT_I, 1'b0, 1'b0, 1'b0, 1'b0, 3'd4);
      default:
             op_ctl = bad_ctl();
    endcase
  end

  always_comb begin
    if (op == '0) begin
      cls = CLS_FUNC;
      ctl = func_ctl;
    end else if (op == OPW'(1)) begin
      cls = CLS_RT;
      ctl = rt_ctl;
    end else begin
      cls = CLS_OP;
      ctl = op_ctl;
    end
  end

endmodule

// File: rtl/idec_operands.sv
module idec_operands
  import idec_pkg::*;
#(
  parameter int LINK_REG = 31
) (
  input  ctl_t            ctl,
  input  logic [RIW-1:0]  rt_f,
  input  logic [RIW-1:0]  rd_f,
  input  logic [RIW-1:0]  sh_f,
  input  logic [IMMW-1:0] imm16,
  input  logic [TGW-1:0]  tgt,
  input  logic [IW-1:0]   npc,
  input  logic [IW-1:0]   rs_val,
  input  logic [IW-1:0]   rt_val,
  output logic            dst_valid,
  output logic [RIW-1:0]  dst_idx,
  output logic [IW-1:0]   imm_x,
  output logic [IW-1:0]   jtgt,
  output logic [IW-1:0]   ea,
  output logic [IW-1:0]   op_a,
  output logic [IW-1:0]   op_b,
  output logic [SZW-1:0]  size,
  output logic            misalign
);

  logic [IW-1:0] imm_signed;

  always_comb begin
    imm_signed = widen_imm(imm16, 1'b0);
    imm_x      = widen_imm(imm16, ctl.zext);
  end

  always_comb begin
    dst_valid = 1'b0;
    dst_idx   = '0;
    if (ctl.legal) begin
      if (ctl.link) begin
        dst_valid = 1'b1;
        dst_idx   = RIW'(LINK_REG);
      end else if (ctl.fmt == FMT_R) begin
        dst_valid = 1'b1;
        dst_idx   = rd_f;
      end else if (ctl.fmt == FMT_I) begin
        dst_valid = 1'b1;
        dst_idx   = rt_f;
      end
    end
  end

  always_comb begin
    case (ctl.fmt)
      FMT_R:   jtgt = rs_val;
      FMT_I:   jtgt = rel_target(npc, imm_signed);
      FMT_J:   jtgt = seg_target(npc[IW-1 -: SEGW], tgt);
      default: jtgt = '1;
    endcase
  end

  always_comb begin
    ea       = rs_val + imm_x;
    op_a     = ctl.sh_is_src1 ? {{(IW-RIW){1'b0}}, sh_f} : rs_val;
    op_b     = ctl.imm_is_src2 ? imm_x : rt_val;
    size     = ctl.legal ? ctl.size : '0;
    misalign = ctl.legal && is_misaligned(ea[1:0], size);
  end

endmodule

// File: rtl/insn_field_decoder.sv
module insn_field_decoder
  import idec_pkg::*;
#(
  parameter int LINK_REG = 31
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [31:0]       instr,
  input  logic [31:0]       next_pc,
  input  logic [31:0]       rs_data,
  input  logic [31:0]       rt_data,
  output logic              out_valid,
  output logic [5:0]        f_op,
  output logic [4:0]        f_rs,
  output logic [4:0]        f_rt,
  output logic [4:0]        f_rd,
  output logic [4:0]        f_sh,
  output logic [5:0]        f_func,
  output logic [25:0]       f_target,
  output logic [1:0]        tbl_class,
  output logic [1:0]        ifmt,
  output logic              illegal,
  output logic              dst_valid,
  output logic [4:0]        dst_idx,
  output logic [31:0]       imm_ext,
  output logic [31:0]       jtarget,
  output logic [31:0]       addr,
  output logic [31:0]       src1,
  output logic [31:0]       src2,
  output logic [2:0]        acc_size,
  output logic              addr_err
);

  logic [OPW-1:0]  w_op;
  logic [RIW-1:0]  w_rs, w_rt, w_rd, w_sh;
  logic [FNW-1:0]  w_fn;
  logic [TGW-1:0]  w_tgt;
  logic [IMMW-1:0] w_imm16;
  cls_e            w_cls;
  ctl_t            w_ctl;
  logic            w_dst_valid;
  logic [RIW-1:0]  w_dst_idx;
  logic [IW-1:0]   w_imm, w_jt, w_ea, w_a, w_b;
  logic [SZW-1:0]  w_size;
  logic            w_misalign;

  idec_fields u_fields (
    .word  (instr),
    .op    (w_op),
    .rs    (w_rs),
    .rt    (w_rt),
    .rd    (w_rd),
    .sh    (w_sh),
    .fn    (w_fn),
    .tgt   (w_tgt),
    .imm16 (w_imm16)
  );

  idec_table u_table (
    .op  (w_op),
    .rt  (w_rt),
    .fn  (w_fn),
    .cls (w_cls),
    .ctl (w_ctl)
  );

  idec_operands #(.LINK_REG(LINK_REG)) u_operands (
    .ctl       (w_ctl),
    .rt_f      (w_rt),
    .rd_f      (w_rd),
    .sh_f      (w_sh),
    .imm16     (w_imm16),
    .tgt       (w_tgt),
    .npc       (next_pc),
    .rs_val    (rs_data),
    .rt_val    (rt_data),
    .dst_valid (w_dst_valid),
    .dst_idx   (w_dst_idx),
    .imm_x     (w_imm),
    .jtgt      (w_jt),
    .ea        (w_ea),
    .op_a      (w_a),
    .op_b      (w_b),
    .size      (w_size),
    .misalign  (w_misalign)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      f_op      <= '0;
      f_rs      <= '0;
      f_rt      <= '0;
      f_rd      <= '0;
      f_sh      <= '0;
      f_func    <= '0;
      f_target  <= '0;
      tbl_class <= '0;
      ifmt      <= '0;
      illegal   <= 1'b0;
      dst_valid <= 1'b0;
      dst_idx   <= '0;
      imm_ext   <= '0;
      jtarget   <= '0;
      addr      <= '0;
      src1      <= '0;
      src2      <= '0;
      acc_size  <= '0;
      addr_err  <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        f_op      <= w_op;
        f_rs      <= w_rs;
        f_rt      <= w_rt;
        f_rd      <= w_rd;
        f_sh      <= w_sh;
        f_func    <= w_fn;
        f_target  <= w_tgt;
        tbl_class <= w_cls;
        ifmt      <= w_ctl.fmt;
        illegal   <= !w_ctl.legal;
        dst_valid <= w_dst_valid;
        dst_idx   <= w_dst_idx;
        imm_ext   <= w_imm;
        jtarget   <= w_jt;
        addr      <= w_ea;
        src1      <= w_a;
        src2      <= w_b;
        acc_size  <= w_size;
        addr_err  <= w_misalign;
      end
    end
  end

endmodule

// File: rtl/insn_field_decoder_chk.sv
module insn_field_decoder_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        in_valid,
  input logic        out_valid,
  input logic [5:0]  f_op,
  input logic [1:0]  ifmt,
  input logic        illegal,
  input logic        dst_valid,
  input logic [4:0]  dst_idx,
  input logic [31:0] imm_ext,
  input logic [31:0] jtarget,
  input logic [31:0] addr,
  input logic [2:0]  acc_size,
  input logic        addr_err
);

  p_valid_follows_r1: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);

  p_idle_follows_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);

  p_illegal_empty_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && illegal) |-> (ifmt == 2'd3 && !dst_valid && acc_size == 3'd0));

  p_link_dst_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !illegal && f_op == 6'h03) |-> (dst_valid && dst_idx == 5'd31));

  p_none_target_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && ifmt == 2'd3) |-> (jtarget == 32'hFFFF_FFFF));

  p_zero_ext_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && f_op[5:2] == 4'b0011) |-> (imm_ext[31:16] == 16'h0000));

  p_size_code_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(acc_size));

  p_misalign_cause_r11: assert property (@(posedge clk) disable iff (!rst_n)
    addr_err |-> (acc_size != 3'd0 && (addr[0] || (acc_size == 3'd4 && addr[1]))));

  p_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> ($stable(addr) && $stable(jtarget) && $stable(imm_ext)));

endmodule

bind insn_field_decoder insn_field_decoder_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .out_valid (out_valid),
  .f_op      (f_op),
  .ifmt      (ifmt),
  .illegal   (illegal),
  .dst_valid (dst_valid),
  .dst_idx   (dst_idx),
  .imm_ext   (imm_ext),
  .jtarget   (jtarget),
  .addr      (addr),
  .acc_size  (acc_size),
  .addr_err  (addr_err)
);

// File: tb/insn_field_decoder_bench.sv
module insn_field_decoder_bench;

  localparam time CLK_P = 10ns;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [31:0] instr = '0, next_pc = '0, rs_data = '0, rt_data = '0;
  logic        out_valid, illegal, dst_valid, addr_err;
  logic [5:0]  f_op, f_func;
  logic [4:0]  f_rs, f_rt, f_rd, f_sh, dst_idx;
  logic [25:0] f_target;
  logic [1:0]  tbl_class, ifmt;
  logic [31:0] imm_ext, jtarget, addr, src1, src2;
  logic [2:0]  acc_size;

  int n_chk = 0;
  int n_fail = 0;

  // expectation of the last accepted word (all zero after reset)
  logic        e_ov = 0, e_ill = 0, e_dv = 0, e_ae = 0;
  logic [31:0] e_word = 0, e_imm = 0, e_jt = 0, e_addr = 0, e_s1 = 0, e_s2 = 0;
  logic [4:0]  e_dst = 0;
  logic [1:0]  e_cls = 0, e_fmt = 0;
  logic [2:0]  e_sz = 0;

  always #(CLK_P/2) clk = ~clk;

  insn_field_decoder u_insn_field_decoder (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .instr(instr),
    .next_pc(next_pc), .rs_data(rs_data), .rt_data(rt_data),
    .out_valid(out_valid), .f_op(f_op), .f_rs(f_rs), .f_rt(f_rt),
    .f_rd(f_rd), .f_sh(f_sh), .f_func(f_func), .f_target(f_target),
    .tbl_class(tbl_class), .ifmt(ifmt), .illegal(illegal),
    .dst_valid(dst_valid), .dst_idx(dst_idx), .imm_ext(imm_ext),
    .jtarget(jtarget), .addr(addr), .src1(src1), .src2(src2),
    .acc_size(acc_size), .addr_err(addr_err)
  );

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // behavioural reference of one accepted word
  task automatic model(input logic [31:0] w, input logic [31:0] npc,
                       input logic [31:0] a, input logic [31:0] b);
    int op, fn, rt;
    bit ok, lnk, shs, ims, zx;
    logic [31:0] se;
    op = int'(w[31:26]); fn = int'(w[5:0]); rt = int'(w[20:16]);
    lnk = 0; shs = 0; ims = 0; zx = 0; e_sz = 0;
    if (op == 0) begin
      e_cls = 2'd1;
      ok  = fn inside {0, 2, 3, 4, 6, 7, 8, 9, [32:39], 42, 43};
      shs = fn inside {0, 2, 3};
      e_fmt = 2'd0;
    end else if (op == 1) begin
      e_cls = 2'd2;
      ok  = rt inside {0, 1, 16, 17};
      lnk = rt >= 16;
      e_fmt = 2'd1;
    end else begin
      e_cls = 2'd0;
      ok  = op inside {[2:15], 32, 33, 35, 36, 37, 40, 41, 43};
      lnk = (op == 3);
      ims = op >= 8 && op <= 15;
      zx  = op >= 12 && op <= 15;
      e_fmt = (op < 4) ? 2'd2 : 2'd1;
      if (op inside {32, 36, 40}) e_sz = 3'd1;
      if (op inside {33, 37, 41}) e_sz = 3'd2;
      if (op inside {35, 43})     e_sz = 3'd4;
    end
    if (!ok) begin
      e_fmt = 2'd3; lnk = 0; shs = 0; ims = 0; zx = 0; e_sz = 0;
    end
    e_ill  = !ok;
    e_word = w;
    se     = 32'(signed'(w[15:0]));
    e_imm  = zx ? {16'h0, w[15:0]} : se;
    if (!ok)             begin e_dv = 0; e_dst = 0; end
    else if (lnk)        begin e_dv = 1; e_dst = 5'd31; end
    else if (e_fmt == 0) begin e_dv = 1; e_dst = w[15:11]; end
    else if (e_fmt == 1) begin e_dv = 1; e_dst = w[20:16]; end
    else                 begin e_dv = 0; e_dst = 0; end
    case (e_fmt)
      2'd0: e_jt = a;
      2'd1: e_jt = npc + se * 4;
      2'd2: e_jt = (npc & 32'hF000_0000) | ({6'b0, w[25:0]} * 4);
      default: e_jt = 32'hFFFF_FFFF;
    endcase
    e_addr = a + e_imm;
    e_s1   = shs ? 32'(w[10:6]) : a;
    e_s2   = ims ? e_imm : b;
    e_ae   = (e_sz == 4 && e_addr % 4 != 0) || (e_sz == 2 && e_addr % 2 != 0);
  endtask

  task automatic compare_all(input bit held);
    chk("R1", "out_valid", 32'(out_valid), 32'(e_ov));
    chk("R1", "fields", {f_op, f_rs, f_rt, f_rd, f_sh, f_func}, e_word);
    chk("R1", "target", 32'(f_target), 32'(e_word[25:0]));
    chk("R2", "class", 32'(tbl_class), 32'(e_cls));
    chk("R3", "illegal", 32'(illegal), 32'(e_ill));
    chk("R4", "format", 32'(ifmt), 32'(e_fmt));
    chk("R4", "dst", {26'b0, dst_valid, dst_idx}, {26'b0, e_dv, e_dst});
    chk("R5", "jtarget", jtarget, e_jt);
    chk("R6", "imm_ext", imm_ext, e_imm);
    chk("R7", "addr", addr, e_addr);
    chk("R8", "src1", src1, e_s1);
    chk("R9", "src2", src2, e_s2);
    chk("R10", "acc_size", 32'(acc_size), 32'(e_sz));
    chk("R11", "addr_err", 32'(addr_err), 32'(e_ae));
    if (held) chk("R12", "held addr", addr, e_addr);
  endtask

  // drive one cycle at the falling edge, then check at the next one
  task automatic step(input bit v, input logic [31:0] w, input logic [31:0] npc,
                      input logic [31:0] a, input logic [31:0] b);
    in_valid = v; instr = w; next_pc = npc; rs_data = a; rt_data = b;
    if (v) model(w, npc, a, b);
    e_ov = v;
    @(negedge clk);
    compare_all(!v);
  endtask

  function automatic logic [31:0] ri(int op, int rs, int rt, int imm);
    return {6'(op), 5'(rs), 5'(rt), 16'(imm)};
  endfunction

  function automatic logic [31:0] rr(int rs, int rt, int rd, int sh, int fn);
    return {6'd0, 5'(rs), 5'(rt), 5'(rd), 5'(sh), 6'(fn)};
  endfunction

  function automatic logic [31:0] rand_word();
    logic [31:0] w;
    int k, r;
    int ops[20] = '{2, 3, 4, 5, 8, 9, 10, 12, 13, 15, 32, 33, 35, 36, 37, 40, 41, 43, 63, 34};
    w = $urandom;
    k = $urandom_range(0, 9);
    if (k < 3) w[31:26] = 6'd0;
    else if (k == 3) begin
      w[31:26] = 6'd1;
      r = $urandom_range(0, 4);
      w[20:16] = (r == 0) ? 5'd0 : (r == 1) ? 5'd1 : (r == 2) ? 5'd16 :
                 (r == 3) ? 5'd17 : 5'd9;
    end else w[31:26] = 6'(ops[$urandom_range(0, 19)]);
    return w;
  endfunction

  initial begin
    #(CLK_P * 200000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    @(negedge clk);
    @(negedge clk);
    compare_all(0);               // R1 reset state
    rst_n = 1'b1;
    @(negedge clk);
    compare_all(0);

    // R4 R5 link jump, jump format
    step(1, {6'd3, 26'h2AB_CDEF}, 32'h9000_0010, 32'h11, 32'h22);
    step(1, {6'd2, 26'h000_0040}, 32'h7FFF_FFF0, 32'h11, 32'h22);
    // R5 backward branch, sign-extended offset
    step(1, ri(4, 3, 4, 16'hFFFC), 32'h0000_1000, 32'h5, 32'h6);
    // R6 R9 zero vs sign extension of immediates
    step(1, ri(12, 1, 2, 16'h8000), 32'h0, 32'hFFFF_FFFF, 32'h7);
    step(1, ri(8, 1, 2, 16'h8000), 32'h0, 32'h0000_0010, 32'h7);
    step(1, ri(15, 0, 9, 16'h1234), 32'h0, 32'h0, 32'h0);
    // R10 R11 alignment corner cases
    step(1, ri(35, 1, 2, 4), 32'h0, 32'h100, 32'h0);
    step(1, ri(35, 1, 2, 2), 32'h0, 32'h100, 32'h0);
    step(1, ri(33, 1, 2, 1), 32'h0, 32'h100, 32'h0);
    step(1, ri(32, 1, 2, 1), 32'h0, 32'h100, 32'h0);
    step(1, ri(43, 1, 2, 16'hFFFF), 32'h0, 32'h100, 32'h0);
    step(1, ri(41, 1, 2, 16'hFFFE), 32'h0, 32'h101, 32'h0);
    // R8 shift amount vs variable shift, R5 register jump
    step(1, rr(7, 8, 9, 17, 0), 32'h0, 32'hABCD, 32'h1);
    step(1, rr(7, 8, 9, 17, 4), 32'h0, 32'hABCD, 32'h1);
    step(1, rr(31, 0, 0, 0, 8), 32'h0, 32'h4000_0000, 32'h1);
    // R3 unsupported encodings in each class
    step(1, {6'd63, 26'h3FF_FFFF}, 32'h10, 32'h3, 32'h3);
    step(1, rr(1, 2, 3, 4, 1), 32'h10, 32'h3, 32'h3);
    step(1, ri(1, 2, 5, 8), 32'h10, 32'h3, 32'h3);
    // R4 link on compare-with-zero class
    step(1, ri(1, 2, 17, 8), 32'h10, 32'h3, 32'h3);
    // R12 idle cycles with changing inputs
    step(0, 32'hFFFF_FFFF, 32'h5, 32'h6, 32'h7);
    step(0, 32'h0, 32'h0, 32'h0, 32'h0);

    for (int i = 0; i < 3000; i++) begin
      step($urandom_range(0, 4) != 0, rand_word(), $urandom, $urandom,
           ($urandom_range(0, 1) == 0) ? 32'h0 : $urandom);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule